// File: doc/BRIEF.md
# First-Order Delta-Sigma DAC

This block turns a parallel unsigned code into a one-bit pulse-density stream. The density of ones tracks the code: a code of zero gives a stream of zeros, and the largest code gives a stream that is almost all ones. An analog low-pass filter placed after the output pin recovers the level.

Each clock, the code is zero-extended by two guard bits. A delta adder combines it with a feedback word. The feedback word holds the present accumulator MSB, copied into its two top bits, with zeros below them. When that bit is 1, the feedback word equals minus full scale in two's complement, so the adder subtracts full scale. A sigma accumulator adds the delta result to its stored sum on every clock. The accumulator MSB is the pulse bit, and it passes through one more register before it reaches the output pin.

Top module: `dsm_dac`

## Requirements
- R1: The code is zero-extended by two bits. While the accumulator MSB is 0, the accumulator grows by exactly the code value on the next clock.
- R2: While the accumulator MSB is 1, the accumulator changes by the code minus 2^CODE_W (16384 by default) on the next clock, modulo 2^(CODE_W+2).
- R3: The accumulator takes a new value on every clock that is not in reset. There is no enable and no hold state.
- R4: `pdm_o` equals the accumulator MSB one clock later. This is the only register between the accumulator and the pin.
- R5: A synchronous reset clears the accumulator and the output register to 0. `pdm_o` reads 0 while reset is held.
- R6: After reset with a code of 0, `pdm_o` stays 0 indefinitely.
- R7: Once settled, with a constant code, the number of ones over any 2^CODE_W consecutive clocks differs from the code by at most 1. This holds from code 1 up to the largest code.
- R8: The two top accumulator bits never both read 1. For every code the sum stays inside its 16-bit range and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_i | input | CODE_W | Unsigned level to convert |
| pdm_o | output | 1 | Registered pulse-density output |

## Verification
The bench builds the block with the default CODE_W of 14. At that width the 16384-clock density window is short enough to measure several codes in full within one run. The codes measured include 1, a mid-scale value, an odd value and full scale minus one. A behavioural integer model of the accumulator predicts `pdm_o` on every clock. A reset in the middle of a run followed by a zero code shows that the state is cleared and that the output then stays silent.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    // Guard bits added above the code so the feedback word can hold -full scale.
    localparam int GUARD_W = 2;

    function automatic int acc_width(input int code_w);
        return code_w + GUARD_W;
    endfunction
endpackage

// File: rtl/dsm_delta.sv
module dsm_delta #(
    parameter int CODE_W = 14,
    localparam int ACC_W = dsm_pkg::acc_width(CODE_W)
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              fb_i,
    output logic [ACC_W-1:0]  delta_o
);
    import dsm_pkg::*;

    typedef struct packed {
        logic [ACC_W-1:0] code_ext;
        logic [ACC_W-1:0] fb_word;
    } opnd_t;

    opnd_t op;

    always_comb begin
        op.code_ext = {{GUARD_W{1'b0}}, code_i};
        op.fb_word  = {{GUARD_W{fb_i}}, {CODE_W{1'b0}}};
        delta_o     = op.code_ext + op.fb_word;
    end
endmodule

// File: rtl/dsm_sigma.sv
module dsm_sigma #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] delta_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             msb_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } sig_t;

    sig_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.acc = s_q.acc + delta_i;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign acc_o = s_q.acc;
    assign msb_o = s_q.acc[ACC_W-1];

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.acc[ACC_W-1 -: 2] != 2'b11);
endmodule

// File: rtl/dsm_outreg.sv
module dsm_outreg (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    output logic bit_o
);
    typedef struct packed {
        logic pdm;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.pdm = bit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign bit_o = o_q.pdm;

    // R4
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> bit_o == $past(bit_i));
    // R5
    out_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !bit_o);
endmodule

// File: rtl/dsm_dac.sv
module dsm_dac #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic              pdm_o
);
    localparam int ACC_W = dsm_pkg::acc_width(CODE_W);
    localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'(1) << CODE_W;

    logic [ACC_W-1:0] delta_w;
    logic [ACC_W-1:0] acc_w;
    logic             msb_w;
    logic [ACC_W-1:0] code_ext_w;

    dsm_delta #(.CODE_W(CODE_W)) u_delta (
        .code_i  (code_i),
        .fb_i    (msb_w),
        .delta_o (delta_w)
    );

    dsm_sigma #(.ACC_W(ACC_W)) u_sigma (
        .clk     (clk),
        .rst     (rst),
        .delta_i (delta_w),
        .acc_o   (acc_w),
        .msb_o   (msb_w)
    );

    dsm_outreg u_out (
        .clk   (clk),
        .rst   (rst),
        .bit_i (msb_w),
        .bit_o (pdm_o)
    );

    assign code_ext_w = ACC_W'(code_i);

    // R1 R3
    step_low_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_w[ACC_W-1] |=> acc_w == $past(acc_w) + $past(code_ext_w));
    // R2 R3
    step_high_chk: assert property (@(posedge clk) disable iff (rst)
        acc_w[ACC_W-1] |=> acc_w == $past(acc_w) + $past(code_ext_w) - FULL_SCALE);
    // R5
    acc_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> acc_w == '0);
endmodule

// File: tb/sim_dsm_dac.sv
`timescale 1ns/1ps
module sim_dsm_dac;
    localparam int CODE_W = 14;
    localparam int FS     = 1 << CODE_W;
    localparam int MODV   = FS * 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CODE_W-1:0] code = '0;
    logic              pdm_o;

    int compared   = 0;
    int mismatched = 0;
    int acc_m      = 0;
    bit out_m      = 1'b0;

    always #2.5 clk = ~clk;

    dsm_dac #(.CODE_W(CODE_W)) u0 (
        .clk    (clk),
        .rst    (rst),
        .code_i (code),
        .pdm_o  (pdm_o)
    );

    // Behavioural reference of the integer accumulator.
    always @(posedge clk) begin
        if (rst) begin
            acc_m = 0;
            out_m = 1'b0;
        end else begin
            out_m = (acc_m >= MODV / 2);
            acc_m = (acc_m + int'(code) - (out_m ? FS : 0) + MODV) % MODV;
        end
    end

    // R3 R4: cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            compared++;
            if (pdm_o !== out_m) begin
                mismatched++;
                $display("FAIL R4 cycle compare: pdm_o=%0b expected %0b", pdm_o, out_m);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic density(input int c);
        int ones = 0;
        int diff;
        code = CODE_W'(c);
        repeat (200) @(negedge clk);
        for (int i = 0; i < FS; i++) begin
            @(negedge clk);
            ones += int'(pdm_o);
        end
        diff = ones - c;
        check(diff >= -1 && diff <= 1, "R7 density", ones, c);
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pdm_o == 1'b0, "R5 reset state", int'(pdm_o), 0);
        rst = 1'b0;
        // R1 R2 R7: densities across the range, large code first to settle quickly
        density(12345);
        density(8192);
        density(1);
        density(FS - 1);
        density(777);
        // R5: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        code = '0;
        @(negedge clk);
        check(pdm_o == 1'b0, "R5 mid-run reset", int'(pdm_o), 0);
        @(negedge clk);
        rst = 1'b0;
        // R6: zero code stays silent
        begin
            int ones0 = 0;
            for (int i = 0; i < 500; i++) begin
                @(negedge clk);
                ones0 += int'(pdm_o);
            end
            check(ones0 == 0, "R6 zero code", ones0, 0);
        end
        // R1: from cleared state, code 8000 needs 5 clocks before the first 1
        code = CODE_W'(8000);
        begin
            int first = -1;
            for (int i = 1; i <= 10; i++) begin
                @(negedge clk);
                if (pdm_o && first < 0) first = i;
            end
            check(first == 6, "R1 first pulse latency", first, 6);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule